// File: doc/BRIEF.md
# Line-based instruction fetch unit

This block is the front end of a small processor with 12-bit words and 15-bit addresses. An address is a 3-bit field above a 12-bit offset. The block holds a fetch PC and a generation tag, and it looks the PC up in a small direct-mapped cache of instruction lines. When the line is present and downstream is ready, it sends one bundle that carries the whole eight-word line, the PC and the generation tag. The PC then moves to the start of the next line. The offset wraps at 4K, and the field never changes.

When the PC misses, the block asks memory for the missing line. A command carries the line address, and the response returns that address with the line data. Only one fill is outstanding at a time. A restart input loads a new PC and a new generation tag, and it drops the claim on any fill still in flight. A stale fill still lands in the cache when it arrives, but it does not hold back the request for the new PC. Downstream uses the generation tag and the first-after-restart flag to discard bundles from an abandoned path.

Top module: `fetch_unit`

## Requirements
- R1: After reset the cache is empty, the PC is 0, the generation tag is 0, `bnd_first_o` is 1, `bnd_valid_o` is 0 and a fill command for line address 0 is offered.
- R2: A fill command is offered only while the PC misses and no fill is outstanding. Its line address is the PC shifted right by 3. A fill counts as outstanding from its command handshake until the next bundle is emitted or the next restart.
- R3: A fill response is written into the cache at the clock edge where `rsp_valid_i` is high. From the next cycle a PC in that line hits. The bundle then carries the line's eight words, with word w in bits [12*w+11:12*w], together with the PC and the current generation tag.
- R4: A bundle is emitted when `bnd_valid_o` and `bnd_ready_i` are both high. After emission the PC is aligned down to a multiple of 8 and increased by 8. Bits [14:12] are kept, and bits [11:0] wrap modulo 4096.
- R5: A restart loads the PC from `restart_pc_i` and the generation tag from `restart_gen_i`, and it clears the outstanding fill. In the restart cycle no bundle and no fill command is offered.
- R6: `bnd_first_o` is 1 on the first bundle after a reset or a restart, and 0 on every bundle after that until the next restart.
- R7: While a bundle is offered and not accepted, the PC and the generation tag stay unchanged.
- R8: A fill that is in flight when a restart arrives does not block a fill for the new PC. Its response is still written into the cache, so a later restart back to that line hits without a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Load a new PC and generation tag |
| restart_pc_i | input | 15 | PC to restart at |
| restart_gen_i | input | 4 | Generation tag to restart with |
| bnd_valid_o | output | 1 | Bundle offered |
| bnd_ready_i | input | 1 | Downstream accepts the bundle |
| bnd_pc_o | output | 15 | PC of the bundle |
| bnd_gen_o | output | 4 | Generation tag of the bundle |
| bnd_first_o | output | 1 | First bundle since reset or restart |
| bnd_data_o | output | 96 | Whole cache line, word w at bits 12w+11..12w |
| cmd_valid_o | output | 1 | Fill command offered |
| cmd_ready_i | input | 1 | Memory accepts the command |
| cmd_line_o | output | 12 | Line address to fill |
| rsp_valid_i | input | 1 | Fill response present |
| rsp_line_i | input | 12 | Line address of the response |
| rsp_data_i | input | 96 | Line data of the response |

## Verification
A wrong PC or generation register shows on the next bundle through `bnd_pc_o` or `bnd_gen_o`, because every bundle is compared with a model built from the restart and advance rules. A stuck outstanding-fill flag shows one of two ways. A command may appear while a fill is still owed, or no bundle ever appears, which the liveness count catches. A corrupt cache entry shows as wrong line data on the first bundle that hits it. A lost stale fill shows as an extra command after the restart back to that line.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int FIELD_W    = 3;
  localparam int OFF_W      = 12;
  localparam int WORD_W     = 12;
  localparam int LINE_WORDS = 8;
  localparam int LINES      = 8;
  localparam int GEN_W      = 4;
endpackage

// File: rtl/fu_line_cache.sv
module fu_line_cache #(
  parameter int LADDR_W = 12,
  parameter int LINES   = 8,
  parameter int LINE_W  = 96
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LADDR_W-1:0] look_line_i,
  output logic               hit_o,
  output logic [LINE_W-1:0]  look_data_o,
  input  logic               wr_en_i,
  input  logic [LADDR_W-1:0] wr_line_i,
  input  logic [LINE_W-1:0]  wr_data_i
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = LADDR_W - IDX_W;

  logic              valid_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [LINE_W-1:0] data_q  [LINES];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_idx = look_line_i[IDX_W-1:0];
  assign rd_tag = look_line_i[LADDR_W-1:IDX_W];
  assign wr_idx = wr_line_i[IDX_W-1:0];
  assign wr_tag = wr_line_i[LADDR_W-1:IDX_W];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
      end else if (wr_en_i && wr_idx == IDX_W'(i)) begin
        valid_q[i] <= 1'b1;
        tag_q[i]   <= wr_tag;
      end
    end
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_idx == IDX_W'(i)) data_q[i] <= wr_data_i;
    end
  end

  assign hit_o       = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign look_data_o = data_q[rd_idx];

  // R3: a written line hits next cycle if the lookup stays on it
  a_r3_fill_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_line_i == look_line_i |=> (look_line_i != $past(look_line_i)) || hit_o);
endmodule

// File: rtl/fu_pc_track.sv
module fu_pc_track #(
  parameter int PC_W     = 15,
  parameter int OFF_W    = 12,
  parameter int LW_LOG   = 3,
  parameter int GEN_W    = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [PC_W-1:0]  restart_pc_i,
  input  logic [GEN_W-1:0] restart_gen_i,
  input  logic             advance_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [GEN_W-1:0] gen_o,
  output logic             first_o
);
  logic [OFF_W-1:0] off_next;
  logic [OFF_W-1:0] off_aligned;

  assign off_aligned = {pc_o[OFF_W-1:LW_LOG], {LW_LOG{1'b0}}};
  assign off_next    = off_aligned + OFF_W'(1 << LW_LOG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o    <= RESET_PC;
      gen_o   <= '0;
      first_o <= 1'b1;
    end else if (restart_i) begin
      pc_o    <= restart_pc_i;
      gen_o   <= restart_gen_i;
      first_o <= 1'b1;
    end else if (advance_i) begin
      pc_o    <= {pc_o[PC_W-1:OFF_W], off_next};
      first_o <= 1'b0;
    end
  end

  a_r5_restart_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> pc_o == $past(restart_pc_i) && gen_o == $past(restart_gen_i) && first_o);
  a_r4_advance_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i && !restart_i |=> pc_o[LW_LOG-1:0] == '0
      && pc_o[PC_W-1:OFF_W] == $past(pc_o[PC_W-1:OFF_W]) && !first_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i && !restart_i |=> $stable(pc_o) && $stable(gen_o));
endmodule

// File: rtl/fu_fill_ctrl.sv
module fu_fill_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic emit_i,
  input  logic miss_i,
  input  logic cmd_ready_i,
  output logic cmd_valid_o
);
  logic pend_q;

  assign cmd_valid_o = !restart_i && !pend_q && miss_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pend_q <= 1'b0;
    else if (restart_i || emit_i)       pend_q <= 1'b0;
    else if (cmd_valid_o && cmd_ready_i) pend_q <= 1'b1;
  end

  // R2: one fill at a time
  a_r2_single_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=> !cmd_valid_o);
  a_r2_no_emit_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i |-> !miss_i);
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int FLD_W  = FIELD_W,
  parameter int OFS_W  = OFF_W,
  parameter int WRD_W  = WORD_W,
  parameter int LWORDS = LINE_WORDS,
  parameter int NLINES = LINES,
  parameter int TAG_GW = GEN_W,
  localparam int PC_W    = FLD_W + OFS_W,
  localparam int LW_LOG  = $clog2(LWORDS),
  localparam int LADDR_W = PC_W - LW_LOG,
  localparam int LINE_W  = WRD_W * LWORDS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic [PC_W-1:0]    restart_pc_i,
  input  logic [TAG_GW-1:0]  restart_gen_i,
  output logic               bnd_valid_o,
  input  logic               bnd_ready_i,
  output logic [PC_W-1:0]    bnd_pc_o,
  output logic [TAG_GW-1:0]  bnd_gen_o,
  output logic               bnd_first_o,
  output logic [LINE_W-1:0]  bnd_data_o,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic [LADDR_W-1:0] cmd_line_o,
  input  logic               rsp_valid_i,
  input  logic [LADDR_W-1:0] rsp_line_i,
  input  logic [LINE_W-1:0]  rsp_data_i
);
  logic            hit;
  logic            emit;
  logic [PC_W-1:0] pc;

  fu_pc_track #(.PC_W(PC_W), .OFF_W(OFS_W), .LW_LOG(LW_LOG), .GEN_W(TAG_GW)) u_pc (
    .clk_i, .rst_ni, .restart_i, .restart_pc_i, .restart_gen_i,
    .advance_i(emit), .pc_o(pc), .gen_o(bnd_gen_o), .first_o(bnd_first_o)
  );

  fu_line_cache #(.LADDR_W(LADDR_W), .LINES(NLINES), .LINE_W(LINE_W)) u_cache (
    .clk_i, .rst_ni, .look_line_i(pc[PC_W-1:LW_LOG]), .hit_o(hit),
    .look_data_o(bnd_data_o), .wr_en_i(rsp_valid_i), .wr_line_i(rsp_line_i),
    .wr_data_i(rsp_data_i)
  );

  fu_fill_ctrl u_fill (
    .clk_i, .rst_ni, .restart_i, .emit_i(emit), .miss_i(!hit),
    .cmd_ready_i, .cmd_valid_o
  );

  // restart wins over emission
  assign bnd_valid_o = !restart_i && hit;
  assign emit        = bnd_valid_o && bnd_ready_i;
  assign bnd_pc_o    = pc;
  assign cmd_line_o  = pc[PC_W-1:LW_LOG];

  a_r6_first_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit && !restart_i |=> !bnd_first_o);
  a_r5_gen_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> $stable(bnd_gen_o));
  a_r2_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bnd_valid_o && cmd_valid_o));
endmodule

// File: tb/fetch_unit_test.sv
module fetch_unit_test;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        restart_i = 0;
  logic [14:0] restart_pc_i = '0;
  logic [3:0]  restart_gen_i = '0;
  logic        bnd_valid_o, bnd_ready_i = 0, bnd_first_o;
  logic [14:0] bnd_pc_o;
  logic [3:0]  bnd_gen_o;
  logic [95:0] bnd_data_o;
  logic        cmd_valid_o, cmd_ready_i = 0;
  logic [11:0] cmd_line_o;
  logic        rsp_valid_i = 0;
  logic [11:0] rsp_line_i = '0;
  logic [95:0] rsp_data_i = '0;

  fetch_unit uut (.*);

  always #2 clk_i = ~clk_i;

  int total = 0, bad = 0, cyc = 0;
  int emit_cnt = 0, issue_cnt = 0;
  logic [14:0] emit_prev, emit_last;
  logic [14:0] exp_pc = '0;
  logic [3:0]  exp_gen = '0;
  logic        exp_first = 1'b1, exp_out = 1'b0;
  logic [11:0] q_line [16];
  int          q_due  [16];
  int          qh = 0, qt = 0, lat_max = 4;
  bit          done = 0;

  function automatic logic [95:0] line_data(input logic [11:0] ln);
    logic [95:0] d;
    for (int w = 0; w < 8; w++) d[w*12 +: 12] = 12'(({20'd0, ln} * 8 + w) * 37 + 11);
    return d;
  endfunction

  function automatic logic [14:0] next_pc(input logic [14:0] p);
    logic [11:0] o;
    o = {p[11:3], 3'b000} + 12'd8;
    return {p[14:12], o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit rs, input logic [14:0] rpc, input logic [3:0] rg,
                      input bit rdy, input bit crdy);
    bit emit, issue;
    @(negedge clk_i);
    restart_i = rs; restart_pc_i = rpc; restart_gen_i = rg;
    bnd_ready_i = rdy; cmd_ready_i = crdy;
    rsp_valid_i = 0;
    if (qh != qt && q_due[qh % 16] <= cyc) begin
      rsp_valid_i = 1;
      rsp_line_i  = q_line[qh % 16];
      rsp_data_i  = line_data(q_line[qh % 16]);
      qh++;
    end
    #1;
    if (rs) chk(!bnd_valid_o && !cmd_valid_o, "R5 quiet in restart cycle",
                {bnd_valid_o, cmd_valid_o}, 0);
    if (bnd_valid_o) begin
      chk(bnd_pc_o == exp_pc, "R4 R7 bundle pc", bnd_pc_o, exp_pc);
      chk(bnd_gen_o == exp_gen, "R5 bundle gen", bnd_gen_o, exp_gen);
      chk(bnd_first_o == exp_first, "R6 first flag", bnd_first_o, exp_first);
      chk(bnd_data_o == line_data(exp_pc[14:3]), "R3 line data", bnd_data_o,
          line_data(exp_pc[14:3]));
    end
    if (exp_out) chk(!cmd_valid_o, "R2 no command while fill owed", cmd_valid_o, 0);
    if (cmd_valid_o) chk(cmd_line_o == exp_pc[14:3], "R2 line address", cmd_line_o, exp_pc[14:3]);
    emit  = bnd_valid_o && rdy;
    issue = cmd_valid_o && crdy;
    if (emit) begin emit_prev = emit_last; emit_last = bnd_pc_o; emit_cnt++; end
    if (issue) begin
      q_line[qt % 16] = cmd_line_o;
      q_due[qt % 16]  = cyc + 1 + int'($urandom_range(lat_max - 1));
      qt++; issue_cnt++;
    end
    if (rs) begin exp_pc = rpc; exp_gen = rg; exp_first = 1; exp_out = 0; end
    else if (emit) begin exp_pc = next_pc(exp_pc); exp_first = 0; exp_out = 0; end
    if (issue) exp_out = 1;
    cyc++;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    // R1 reset state
    chk(!bnd_valid_o, "R1 no bundle after reset", bnd_valid_o, 0);
    chk(cmd_valid_o && cmd_line_o == 12'd0, "R1 first fill line 0", {cmd_valid_o, cmd_line_o}, {1'b1, 12'd0});
    chk(bnd_first_o && bnd_gen_o == 4'd0, "R1 first flag and gen", {bnd_first_o, bnd_gen_o}, {1'b1, 4'd0});

    // R3 fill then stream from reset PC
    repeat (40) step(0, '0, '0, 1, 1);
    chk(emit_cnt >= 3, "R3 bundles after fills", emit_cnt, 3);

    // R4 wrap inside the 4K field
    step(1, 15'o37775, 4'd7, 1, 1);
    base = emit_cnt;
    for (int i = 0; i < 60 && emit_cnt < base + 2; i++) step(0, '0, '0, 1, 1);
    chk(emit_prev == 15'o37775, "R4 mid-line restart pc", emit_prev, 15'o37775);
    chk(emit_last == 15'o30000, "R4 offset wraps field kept", emit_last, 15'o30000);

    // R8 stale fill still lands, new fill not blocked
    lat_max = 6;
    step(1, 15'o01000, 4'd3, 0, 1);
    for (int i = 0; i < 10 && !cmd_valid_o; i++) step(0, '0, '0, 0, 1);
    step(0, '0, '0, 0, 1);
    base = issue_cnt;
    step(1, 15'o02010, 4'd4, 0, 1);
    repeat (12) step(0, '0, '0, 0, 1);
    chk(issue_cnt == base + 1, "R8 fill for new pc issued", issue_cnt, base + 1);
    chk(bnd_valid_o && bnd_pc_o == 15'o02010, "R7 held bundle", bnd_pc_o, 15'o02010);
    base = issue_cnt;
    step(1, 15'o01000, 4'd5, 0, 1);
    step(0, '0, '0, 1, 1);
    chk(issue_cnt == base, "R8 stale line reused no command", issue_cnt, base);
    chk(emit_last == 15'o01000, "R8 stale line emitted", emit_last, 15'o01000);

    // R4 gen wrap and random mix
    lat_max = 4;
    base = emit_cnt;
    for (int i = 0; i < 4000; i++) begin
      bit rs;
      logic [14:0] rp;
      rs = ($urandom_range(39) == 0);
      rp = ($urandom_range(1) == 0) ? 15'($urandom) : {3'd2, 9'($urandom_range(5)), 3'($urandom)};
      step(rs, rp, 4'($urandom), $urandom_range(3) != 0, $urandom_range(3) != 0);
    end
    chk(emit_cnt > base + 200, "R3 liveness under random mix", emit_cnt - base, 200);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule